// File: doc/BRIEF.md
# Power-Management Wake Controller

This block holds the power-management state of a network interface function and decides when that function asks the host to wake it. Software reaches it through a small configuration-space port: one word holds the power-state field, the wake-request enable and the sticky wake status. A second word holds one enable per wake source. Three pre-synchronized pulse inputs report a link-status change in either direction, a magic-packet match and a wake-up-frame match.

An enabled source that pulses latches the wake status. While both the status and the wake-request enable are set, the block drives the shared active-low wake line through an output enable, with a constant low level. The request stays on until software writes 1 to the status bit or turns the enable off. A separate input tells the block when main power is lost. It then reports the cold sleep state, refuses configuration accesses, and keeps its wake logic running on auxiliary power. The status survives a return to full power.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset, pwr_state is 00 (D0), pme_oe is 0, and both registers read as 0.
- R2: Bits 1:0 at offset 0x54 hold the power state, with 00 for D0 and 11 for D3hot. Writing 00 or 11 moves pwr_state to that value. Writing 01 or 10 leaves the state unchanged, and it reads back through bits 1:0.
- R3: Bit 8 at offset 0x54 is the wake-request enable. It is plain read/write.
- R4: Bit 15 at offset 0x54 is the wake status. Writing 1 to it clears it, and writing 0 to it has no effect.
- R5: At offset 0x40, bit 29 enables the link-change source, bit 28 the wake-frame source and bit 27 the magic-packet source. A pulse from a source sets the status on the next clock edge only if that source's enable is 1.
- R6: pme_oe equals status AND enable. Once on, it stays on until software clears bit 15 or bit 8, and setting bit 8 again while the status is still set turns it back on.
- R7: A qualified event in the same cycle as a write-1-to-clear leaves the status set. Simultaneous events on several sources set the status once.
- R8: While main_pwr_ok is 0, pwr_state reads 10 (D3cold), configuration reads return 0 and writes are ignored, and enabled events still set the status. One edge after power returns, the state goes to D0 while the status and enables are kept.
- R9: A change of power state clears neither the status nor pme_oe.
- R10: In D3hot, configuration reads and writes at both offsets work as in D0.
- R11: Reads of any other offset return 0, and writes there change no register.
- R12: pme_level is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (auxiliary power-on) |
| main_pwr_ok | input | 1 | 1 while main power is present; 0 means cold sleep |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr (combinational) |
| ev_link_chg | input | 1 | Link-status change pulse |
| ev_frame_match | input | 1 | Wake-up-frame match pulse |
| ev_magic_match | input | 1 | Magic-packet match pulse |
| pwr_state | output | 2 | Current power state: 00 D0, 11 D3hot, 10 D3cold |
| pme_oe | output | 1 | Drive enable for the open-drain wake line (1 pulls it low) |
| pme_level | output | 1 | Level driven on the wake line when enabled, always 0 |

## Verification
The bench tries all eight source-enable settings against all eight event patterns. This shows whether each event is gated by its own enable bit and not a neighbour's, and whether several events at once merge into one status. The power-state field is tried with all four codes from both legal starting states, which shows legal moves apart from ignored reserved codes. Separate sequences cover the clear and enable writes while the request is on, an event that coincides with a clear, and a loss and return of main power. They show whether the request is held, released and restored exactly when software or power dictates.

// File: rtl/pwr_wake_pkg.sv
`timescale 1ns/1ps
package pwr_wake_pkg;
  typedef enum logic [1:0] {
    PM_D0     = 2'b00,
    PM_D3COLD = 2'b10,
    PM_D3HOT  = 2'b11
  } pm_state_e;

  // wake sources, index order matches the enable field bit order
  localparam int unsigned NUM_SRC   = 3;
  localparam int unsigned SRC_MAGIC = 0;
  localparam int unsigned SRC_FRAME = 1;
  localparam int unsigned SRC_LINK  = 2;

  // field positions
  localparam int unsigned PS_LSB      = 0;
  localparam int unsigned PS_W        = 2;
  localparam int unsigned PME_EN_BIT  = 8;
  localparam int unsigned PME_STS_BIT = 15;
  localparam int unsigned SRC_EN_LSB  = 27;
endpackage

// File: rtl/pwr_rst_sync.sv
`timescale 1ns/1ps
module pwr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/pwr_cfg_decode.sv
`timescale 1ns/1ps
module pwr_cfg_decode #(
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] PMCSR_OFS = 'h54,
  parameter logic [ADDR_W-1:0] USER_OFS  = 'h40
) (
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              access_ok,
  output logic              sel_pmcsr,
  output logic              sel_user,
  output logic              wr_pmcsr,
  output logic              wr_user
);
  always_comb begin
    sel_pmcsr = access_ok && (cfg_addr == PMCSR_OFS);
    sel_user  = access_ok && (cfg_addr == USER_OFS);
    wr_pmcsr  = sel_pmcsr && cfg_wr;
    wr_user   = sel_user && cfg_wr;
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
`timescale 1ns/1ps
module pwr_state_ctrl
  import pwr_wake_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            main_pwr_ok,
  input  logic            wr_pmcsr,
  input  logic [PS_W-1:0] wr_state,
  output pm_state_e       state_q,
  output logic            access_ok
);
  pm_state_e state_d;
  logic      state_ce;
  logic      legal_req;

  assign legal_req = (wr_state == PM_D0) || (wr_state == PM_D3HOT);

  always_comb begin
    state_d  = state_q;
    state_ce = 1'b0;
    if (!main_pwr_ok) begin
      state_d  = PM_D3COLD;
      state_ce = (state_q != PM_D3COLD);
    end else if (state_q == PM_D3COLD) begin
      state_d  = PM_D0;
      state_ce = 1'b1;
    end else if (wr_pmcsr && legal_req) begin
      state_d  = pm_state_e'(wr_state);
      state_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= PM_D0;
    else if (state_ce) state_q <= state_d;
  end

  assign access_ok = main_pwr_ok && (state_q != PM_D3COLD);

  AST_RSV_STATE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (main_pwr_ok && wr_pmcsr && !legal_req) |=> (state_q == $past(state_q))); // R2
  AST_COLD_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !main_pwr_ok |=> (state_q == PM_D3COLD)); // R8
  AST_COLD_EXIT_D0: assert property (@(posedge clk) disable iff (!rst_n)
    (main_pwr_ok && state_q == PM_D3COLD) |=> (state_q == PM_D0)); // R8
endmodule

// File: rtl/wake_status_core.sv
`timescale 1ns/1ps
module wake_status_core #(
  parameter int unsigned NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_user,
  input  logic [NSRC-1:0] wr_src_en,
  input  logic            wr_pmcsr,
  input  logic            wr_pme_en,
  input  logic            wr_sts_clr,
  input  logic [NSRC-1:0] evt,
  output logic [NSRC-1:0] src_en_q,
  output logic            pme_en_q,
  output logic            pme_sts_q
);
  logic [NSRC-1:0] evt_hit;
  logic            any_hit;
  logic            sts_d, sts_ce;

  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    assign evt_hit[i] = evt[i] & src_en_q[i];
  end
  assign any_hit = |evt_hit;

  always_comb begin
    sts_d  = pme_sts_q;
    sts_ce = 1'b0;
    if (any_hit) begin
      sts_d  = 1'b1;
      sts_ce = 1'b1;
    end else if (wr_pmcsr && wr_sts_clr) begin
      sts_d  = 1'b0;
      sts_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       src_en_q <= '0;
    else if (wr_user) src_en_q <= wr_src_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pme_en_q <= 1'b0;
    else if (wr_pmcsr) pme_en_q <= wr_pme_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pme_sts_q <= 1'b0;
    else if (sts_ce) pme_sts_q <= sts_d;
  end

  AST_STS_SET_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & src_en_q)) |=> pme_sts_q); // R5
  AST_STS_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pme_sts_q && !(|(evt & src_en_q))) |=> !pme_sts_q); // R5
  AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pmcsr && wr_sts_clr && !(|(evt & src_en_q))) |=> !pme_sts_q); // R4
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_sts_q && !(wr_pmcsr && wr_sts_clr)) |=> pme_sts_q); // R7
endmodule

// File: rtl/pwr_wake_ctrl.sv
`timescale 1ns/1ps
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [ADDR_W-1:0] PMCSR_OFS = 'h54,
  parameter logic [ADDR_W-1:0] USER_OFS  = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_pwr_ok,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              ev_link_chg,
  input  logic              ev_frame_match,
  input  logic              ev_magic_match,
  output logic [1:0]        pwr_state,
  output logic              pme_oe,
  output logic              pme_level
);
  logic               rst_n_s;
  logic               access_ok;
  logic               sel_pmcsr, sel_user, wr_pmcsr, wr_user;
  pm_state_e          state_q;
  logic [NUM_SRC-1:0] evt_vec;
  logic [NUM_SRC-1:0] src_en_q;
  logic               pme_en_q, pme_sts_q;
  logic               unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  pwr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  pwr_cfg_decode #(
    .ADDR_W    (ADDR_W),
    .PMCSR_OFS (PMCSR_OFS),
    .USER_OFS  (USER_OFS)
  ) u_decode (
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .access_ok (access_ok),
    .sel_pmcsr (sel_pmcsr),
    .sel_user  (sel_user),
    .wr_pmcsr  (wr_pmcsr),
    .wr_user   (wr_user)
  );

  pwr_state_ctrl u_state (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .main_pwr_ok (main_pwr_ok),
    .wr_pmcsr    (wr_pmcsr),
    .wr_state    (cfg_wdata[PS_LSB +: PS_W]),
    .state_q     (state_q),
    .access_ok   (access_ok)
  );

  always_comb begin
    evt_vec            = '0;
    evt_vec[SRC_MAGIC] = ev_magic_match;
    evt_vec[SRC_FRAME] = ev_frame_match;
    evt_vec[SRC_LINK]  = ev_link_chg;
  end

  wake_status_core #(.NSRC(NUM_SRC)) u_status (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_user    (wr_user),
    .wr_src_en  (cfg_wdata[SRC_EN_LSB +: NUM_SRC]),
    .wr_pmcsr   (wr_pmcsr),
    .wr_pme_en  (cfg_wdata[PME_EN_BIT]),
    .wr_sts_clr (cfg_wdata[PME_STS_BIT]),
    .evt        (evt_vec),
    .src_en_q   (src_en_q),
    .pme_en_q   (pme_en_q),
    .pme_sts_q  (pme_sts_q)
  );

  always_comb begin
    cfg_rdata = '0;
    if (sel_pmcsr) begin
      cfg_rdata[PS_LSB +: PS_W] = state_q;
      cfg_rdata[PME_EN_BIT]     = pme_en_q;
      cfg_rdata[PME_STS_BIT]    = pme_sts_q;
    end
    if (sel_user) begin
      cfg_rdata[SRC_EN_LSB +: NUM_SRC] = src_en_q;
    end
  end

  assign pwr_state = state_q;
  assign pme_oe    = pme_sts_q & pme_en_q;
  assign pme_level = 1'b0;

  AST_PME_HELD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pme_oe && !wr_pmcsr) |=> pme_oe); // R6
  AST_COLD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pwr_state == PM_D3COLD) |-> (cfg_rdata == '0)); // R8
  AST_STATE_KEEPS_PME: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pme_oe && wr_pmcsr && !cfg_wdata[PME_STS_BIT] && cfg_wdata[PME_EN_BIT]) |=> pme_oe); // R9
endmodule

// File: tb/pwr_wake_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_wake_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        main_pwr_ok;
  logic        cfg_wr;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        ev_link_chg, ev_frame_match, ev_magic_match;
  logic [1:0]  pwr_state;
  logic        pme_oe, pme_level;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [7:0] OFS_PM   = 8'h54;
  localparam logic [7:0] OFS_USER = 8'h40;

  always #2.5 clk = ~clk;

  pwr_wake_ctrl u_pwr_wake_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .main_pwr_ok    (main_pwr_ok),
    .cfg_wr         (cfg_wr),
    .cfg_addr       (cfg_addr),
    .cfg_wdata      (cfg_wdata),
    .cfg_rdata      (cfg_rdata),
    .ev_link_chg    (ev_link_chg),
    .ev_frame_match (ev_frame_match),
    .ev_magic_match (ev_magic_match),
    .pwr_state      (pwr_state),
    .pme_oe         (pme_oe),
    .pme_level      (pme_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_addr  = a;
    cfg_wdata = d;
    cfg_wr    = 1'b1;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    cfg_wr   = 1'b0;
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  // ev = {link, frame, magic}
  task automatic pulse(input logic [2:0] ev);
    {ev_link_chg, ev_frame_match, ev_magic_match} = ev;
    @(negedge clk);
    {ev_link_chg, ev_frame_match, ev_magic_match} = 3'b000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; main_pwr_ok = 1'b1; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    ev_link_chg = 1'b0; ev_frame_match = 1'b0; ev_magic_match = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    chk("R1 state", {30'd0, pwr_state}, 32'd0);
    chk("R1 pme_oe", {31'd0, pme_oe}, 32'd0);
    rd(OFS_PM, r);   chk("R1 pm reg", r, 32'd0);
    rd(OFS_USER, r); chk("R1 user reg", r, 32'd0);
    chk("R12 level", {31'd0, pme_level}, 32'd0);

    // R11 unmapped offsets
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h44, r);    chk("R11 read 0x44", r, 32'd0);
    rd(8'h00, r);    chk("R11 read 0x00", r, 32'd0);
    rd(OFS_PM, r);   chk("R11 pm untouched", r, 32'd0);
    rd(OFS_USER, r); chk("R11 user untouched", r, 32'd0);

    // R2 power-state sweep from both legal states over all codes
    for (int f = 0; f < 2; f++) begin
      for (int t = 0; t < 4; t++) begin
        logic [1:0] from_s, exp_s;
        from_s = (f == 0) ? 2'b00 : 2'b11;
        exp_s  = (t == 0 || t == 3) ? 2'(t) : from_s;
        wr(OFS_PM, {30'd0, from_s});
        wr(OFS_PM, {30'd0, 2'(t)});
        chk("R2 state port", {30'd0, pwr_state}, {30'd0, exp_s});
        rd(OFS_PM, r);
        chk("R2 readback", r, {30'd0, exp_s});
      end
    end
    wr(OFS_PM, 32'd0);

    // R3 enable read/write
    wr(OFS_PM, 32'h0000_0100); rd(OFS_PM, r); chk("R3 enable set", r, 32'h0000_0100);
    wr(OFS_PM, 32'h0000_0000); rd(OFS_PM, r); chk("R3 enable clr", r, 32'h0000_0000);

    // R5/R7 exhaustive enable x event sweep, checking R6 output too
    for (int en = 0; en < 8; en++) begin
      for (int ev = 0; ev < 8; ev++) begin
        logic hit;
        hit = |(3'(en) & 3'(ev));
        wr(OFS_USER, 32'(en) << 27);
        wr(OFS_PM, 32'h0000_8100);
        pulse(3'(ev));
        rd(OFS_PM, r);
        chk("R5 status vs source enable", {31'd0, r[15]}, {31'd0, hit});
        chk("R6 pme_oe follows status", {31'd0, pme_oe}, {31'd0, hit});
      end
    end
    rd(OFS_USER, r); chk("R5 user readback", r, 32'h3800_0000);

    // R4 write 0 to status is no-op, write 1 clears
    wr(OFS_PM, 32'h0000_8100);
    pulse(3'b100);
    wr(OFS_PM, 32'h0000_0100);
    rd(OFS_PM, r); chk("R4 write0 keeps", r, 32'h0000_8100);
    wr(OFS_PM, 32'h0000_8100);
    rd(OFS_PM, r); chk("R4 write1 clears", r, 32'h0000_0100);
    chk("R4 pme released", {31'd0, pme_oe}, 32'd0);

    // R6 hold, release by enable, restore
    pulse(3'b010);
    cyc(5);
    chk("R6 held", {31'd0, pme_oe}, 32'd1);
    wr(OFS_PM, 32'h0000_0000);
    chk("R6 enable off releases", {31'd0, pme_oe}, 32'd0);
    rd(OFS_PM, r); chk("R6 status kept", r, 32'h0000_8000);
    wr(OFS_PM, 32'h0000_0100);
    chk("R6 re-enable reasserts", {31'd0, pme_oe}, 32'd1);

    // R7 event coincides with clear
    ev_magic_match = 1'b1;
    wr(OFS_PM, 32'h0000_8100);
    ev_magic_match = 1'b0;
    rd(OFS_PM, r); chk("R7 event beats clear", r, 32'h0000_8100);

    // R9 / R10 state changes keep status; D3hot access works
    wr(OFS_PM, 32'h0000_0103);
    chk("R9 state d3hot", {30'd0, pwr_state}, 32'd3);
    chk("R9 pme kept", {31'd0, pme_oe}, 32'd1);
    wr(OFS_USER, 32'h1000_0000);
    rd(OFS_USER, r); chk("R10 user write in d3hot", r, 32'h1000_0000);
    wr(OFS_PM, 32'h0000_8103);
    rd(OFS_PM, r); chk("R10 clear in d3hot", r, 32'h0000_0103);
    pulse(3'b010);
    wr(OFS_PM, 32'h0000_0100);
    rd(OFS_PM, r); chk("R9 back to d0 keeps status", r, 32'h0000_8100);
    chk("R9 pme after d0", {31'd0, pme_oe}, 32'd1);

    // R8 loss of main power
    wr(OFS_USER, 32'h3800_0000);
    wr(OFS_PM, 32'h0000_8103);
    main_pwr_ok = 1'b0;
    cyc(1);
    chk("R8 cold state", {30'd0, pwr_state}, 32'h2);
    rd(OFS_PM, r); chk("R8 cold read", r, 32'd0);
    wr(OFS_PM, 32'h0000_0000);
    chk("R8 no pme yet", {31'd0, pme_oe}, 32'd0);
    pulse(3'b100);
    chk("R8 event in cold", {31'd0, pme_oe}, 32'd1);
    main_pwr_ok = 1'b1;
    cyc(1);
    chk("R8 back to d0", {30'd0, pwr_state}, 32'd0);
    rd(OFS_PM, r); chk("R8 context kept", r, 32'h0000_8100);
    rd(OFS_USER, r); chk("R8 enables kept", r, 32'h3800_0000);
    chk("R12 level", {31'd0, pme_level}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule